// File: doc/BRIEF.md
# Flash Program/Erase Status Flag Generator

This block models the word a parallel flash array returns to the host while an embedded program or erase algorithm runs. A host starts a program (address plus data) or a sector erase. An external algorithm timer model then reports completion or expiry. While the operation is pending, qualified reads return a status word instead of array contents. In that word a toggle flag inverts on every status read, and an error flag reports failure.

Programming can only clear bits. An attempt to set a bit that already reads 0 is refused at once: the error flag rises and the array is left untouched. During an erase, only even addresses inside the target sector return status. Every other address keeps returning stored data. After an error the block keeps reporting status until the host issues a reset command. After a successful operation, reads return the stored word again, so the host can compare it with the data it intended to write.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the array holds all ones (0xFFFF per word), the block is idle, `rvalid_o` is 0 and `rdata_o` is 0.
- R2: While a program is pending, every read returns a status word. Bits 6 and 14 carry the toggle flag, bits 5 and 13 carry the error flag, and all other bits are 0. The toggle flag is 0 on the first status read after a start and inverts on each later status read.
- R3: A program that completes with `done_i` stores old_word AND new_data at the target address and returns to idle, after which reads return array data.
- R4: A program start whose data has a 1 where the stored word has a 0 enters the error state at once, leaves the array unchanged, and reports the error flag as 1 in status reads.
- R5: `timeout_i` during a pending operation enters the error state. Status reads then show the error flag at 1 while the toggle flag keeps inverting.
- R6: The error state persists until `reset_cmd_i`, which returns the block to idle. `reset_cmd_i` has no effect in any other state.
- R7: During an erase, a read returns status only when the address is even (bit 0 is 0) and its upper bits (above bit SECT_W-1) equal those of the erase target. All other reads return array data unchanged, and they do not advance the toggle flag.
- R8: An erase that completes with `done_i` sets every word of the target sector to 0xFFFF and leaves other sectors intact.
- R9: Start requests are ignored unless the block is idle. `done_i` and `timeout_i` are ignored while idle.
- R10: `rvalid_o` rises in the cycle after `rd_i` and only then. `rdata_o` holds its value between reads.
- R11: When `done_i` and `timeout_i` arrive in the same cycle, the timeout wins and the block enters the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Read word address |
| start_prog_i | input | 1 | Start program request |
| start_erase_i | input | 1 | Start sector erase request |
| op_addr_i | input | ADDR_W | Target address for a start request |
| op_data_i | input | 16 | Program data for a start request |
| done_i | input | 1 | Algorithm finished |
| timeout_i | input | 1 | Algorithm timer expired |
| reset_cmd_i | input | 1 | Return from error state to idle |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 16 | Status word or array data |

## Verification
A wrong state register or target latch shows up at the next qualified read. The word returned one cycle after the strobe is then array data where status was expected, or the reverse. It may also show the wrong error flag. A toggle register that misses an inversion, or advances on an unqualified read, breaks the alternation on the next status read. A faulty array update stays hidden until the affected address is read after the operation ends. The reference model is therefore compared on every read, and the bench reads back the touched words and their neighbours after each operation.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ERR  = 2'd2
  } op_state_e;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  // toggle on bits 6/14, error on bits 5/13, rest zero
  function automatic logic [DATA_W-1:0] status_word(input logic tog, input logic err);
    logic [DATA_W-1:0] w;
    w     = '0;
    w[14] = tog;
    w[6]  = tog;
    w[13] = err;
    w[5]  = err;
    return w;
  endfunction
endpackage

// File: rtl/fsg_array.sv
module fsg_array
  import flash_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rword_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [DATA_W-1:0] chk_data_i,
  output logic              conflict_o,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              erase_we_i,
  input  logic [ADDR_W-1:0] erase_addr_i
);
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam int unsigned SEC_IDX_W = ADDR_W - SECT_W;

  logic [DATA_W-1:0] word_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [ADDR_W-1:0]    WADDR = ADDR_W'(g);
    localparam logic [SEC_IDX_W-1:0] WSEC  = SEC_IDX_W'(g >> SECT_W);
    logic [DATA_W-1:0] word_q;
    logic              prog_hit;
    logic              erase_hit;

    assign prog_hit  = prog_we_i && (prog_addr_i == WADDR);
    assign erase_hit = erase_we_i && (erase_addr_i[ADDR_W-1:SECT_W] == WSEC);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        word_q <= '1;
      else if (prog_hit)  word_q <= word_q & prog_data_i;
      else if (erase_hit) word_q <= '1;
    end

    assign word_w[g] = word_q;
  end

  assign rword_o    = word_w[raddr_i];
  // a 1 requested where the cell already holds 0
  assign conflict_o = |(chk_data_i & ~word_w[chk_addr_i]);
endmodule

// File: rtl/fsg_op_ctrl.sv
module fsg_op_ctrl
  import flash_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic              done_i,
  input  logic              timeout_i,
  input  logic              reset_cmd_i,
  input  logic              conflict_i,
  output op_state_e         state_o,
  output op_kind_e          kind_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic              start_acc_o,
  output logic              commit_prog_o,
  output logic              commit_erase_o
);
  op_state_e         state_q, state_d;
  op_kind_e          kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              finish_ok;

  assign finish_ok      = (state_q == ST_BUSY) && done_i && !timeout_i;
  assign commit_prog_o  = finish_ok && (kind_q == OP_PROG);
  assign commit_erase_o = finish_ok && (kind_q == OP_ERASE);
  assign start_acc_o    = (state_q == ST_IDLE) && (start_prog_i || start_erase_i);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    data_d  = data_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_prog_i) begin
          kind_d  = OP_PROG;
          addr_d  = op_addr_i;
          data_d  = op_data_i;
          state_d = conflict_i ? ST_ERR : ST_BUSY;
        end else if (start_erase_i) begin
          kind_d  = OP_ERASE;
          addr_d  = op_addr_i;
          state_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (timeout_i)   state_d = ST_ERR;
        else if (done_i) state_d = ST_IDLE;
      end
      ST_ERR: begin
        if (reset_cmd_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign state_o    = state_q;
  assign kind_o     = kind_q;
  assign tgt_addr_o = addr_q;
  assign tgt_data_o = data_q;
endmodule

// File: rtl/fsg_rd_path.sv
module fsg_rd_path
  import flash_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  op_state_e         state_i,
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic              start_acc_i,
  input  logic [DATA_W-1:0] rword_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stat_o
);
  logic stat_sel;
  logic in_sector;
  logic tog_q;
  logic stat_q;
  logic rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign in_sector = (addr_i[ADDR_W-1:SECT_W] == tgt_addr_i[ADDR_W-1:SECT_W]) && !addr_i[0];
  assign stat_sel  = (state_i != ST_IDLE) && ((kind_i == OP_PROG) || in_sector);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q    <= 1'b0;
      stat_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_i;
      if (start_acc_i) begin
        tog_q <= 1'b0;
      end else if (rd_i && stat_sel) begin
        tog_q <= ~tog_q;
      end
      if (rd_i) begin
        stat_q  <= stat_sel;
        rdata_q <= stat_sel ? status_word(tog_q, state_i == ST_ERR) : rword_i;
      end
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign stat_o   = stat_q;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [15:0]       op_data_i,
  input  logic              done_i,
  input  logic              timeout_i,
  input  logic              reset_cmd_i,
  output logic              rvalid_o,
  output logic [15:0]       rdata_o
);
  op_state_e         state_q;
  op_kind_e          kind_q;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;
  logic              start_acc;
  logic              commit_prog;
  logic              commit_erase;
  logic              conflict;
  logic [DATA_W-1:0] rword;
  logic              rd_stat;

  fsg_op_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_prog_i   (start_prog_i),
    .start_erase_i  (start_erase_i),
    .op_addr_i      (op_addr_i),
    .op_data_i      (op_data_i),
    .done_i         (done_i),
    .timeout_i      (timeout_i),
    .reset_cmd_i    (reset_cmd_i),
    .conflict_i     (conflict),
    .state_o        (state_q),
    .kind_o         (kind_q),
    .tgt_addr_o     (tgt_addr),
    .tgt_data_o     (tgt_data),
    .start_acc_o    (start_acc),
    .commit_prog_o  (commit_prog),
    .commit_erase_o (commit_erase)
  );

  fsg_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .raddr_i      (addr_i),
    .rword_o      (rword),
    .chk_addr_i   (op_addr_i),
    .chk_data_i   (op_data_i),
    .conflict_o   (conflict),
    .prog_we_i    (commit_prog),
    .prog_addr_i  (tgt_addr),
    .prog_data_i  (tgt_data),
    .erase_we_i   (commit_erase),
    .erase_addr_i (tgt_addr)
  );

  fsg_rd_path #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .addr_i      (addr_i),
    .state_i     (state_q),
    .kind_i      (kind_q),
    .tgt_addr_i  (tgt_addr),
    .start_acc_i (start_acc),
    .rword_i     (rword),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o),
    .stat_o      (rd_stat)
  );
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
  import flash_stat_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic        timeout_i,
  input logic        reset_cmd_i,
  input logic        rvalid_o,
  input logic [15:0] rdata_o,
  input op_state_e   state_q,
  input logic        rd_stat
);
  a_r10_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  a_r10_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  a_r2_status_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && rd_stat) |->
      ((rdata_o & 16'h9F9F) == 16'h0000) && (rdata_o[14] == rdata_o[6]) &&
      (rdata_o[13] == rdata_o[5]));

  a_r5_timeout_to_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && timeout_i) |=> (state_q == ST_ERR));

  a_r6_err_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR && !reset_cmd_i) |=> (state_q == ST_ERR));

  a_r4_err_flag_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state_q == ST_ERR) |=> (!rd_stat || (rdata_o[5] && rdata_o[13])));
endmodule

bind flash_status_gen fsg_checker u_fsg_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .timeout_i   (timeout_i),
  .reset_cmd_i (reset_cmd_i),
  .rvalid_o    (rvalid_o),
  .rdata_o     (rdata_o),
  .state_q     (state_q),
  .rd_stat     (rd_stat)
);

// File: tb/flash_status_gen_tb_top.sv
`timescale 1ns/1ps
module flash_status_gen_tb_top;
  localparam int AW = 5;
  localparam int SW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic start_prog_i = 1'b0;
  logic start_erase_i = 1'b0;
  logic [AW-1:0] op_addr_i = '0;
  logic [15:0] op_data_i = '0;
  logic done_i = 1'b0;
  logic timeout_i = 1'b0;
  logic reset_cmd_i = 1'b0;
  logic rvalid_o;
  logic [15:0] rdata_o;

  always #2 clk_i = ~clk_i;

  flash_status_gen #(.ADDR_W(AW), .SECT_W(SW)) dut_i (.*);

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model: 0 idle, 1 busy, 2 error; kind 0 program, 1 erase
  int m_st = 0;
  int m_kind = 0;
  int m_taddr = 0;
  logic [15:0] m_tdata = '0;
  bit m_tog = 0;
  logic [15:0] m_mem [DEPTH];
  bit exp_v = 0;
  logic [15:0] exp_d = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_kind = 0; m_tog = 0; exp_v = 0; exp_d = '0;
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
    end else begin
      exp_v = rd_i;
      if (rd_i) begin
        bit stat;
        stat = (m_st != 0) && (m_kind == 0 ||
               ((int'(addr_i) >> SW) == (m_taddr >> SW) && addr_i[0] == 1'b0));
        if (stat) begin
          exp_d = 16'h0000;
          exp_d[14] = m_tog; exp_d[6] = m_tog;
          exp_d[13] = (m_st == 2); exp_d[5] = (m_st == 2);
          m_tog = ~m_tog;
        end else begin
          exp_d = m_mem[addr_i];
        end
      end
      case (m_st)
        0: if (start_prog_i) begin
             m_kind = 0; m_taddr = int'(op_addr_i); m_tdata = op_data_i; m_tog = 0;
             m_st = ((op_data_i & ~m_mem[op_addr_i]) != 16'h0) ? 2 : 1;
           end else if (start_erase_i) begin
             m_kind = 1; m_taddr = int'(op_addr_i); m_tog = 0; m_st = 1;
           end
        1: if (timeout_i) m_st = 2;
           else if (done_i) begin
             if (m_kind == 0) m_mem[m_taddr] = m_mem[m_taddr] & m_tdata;
             else for (int i = 0; i < DEPTH; i++)
               if ((i >> SW) == (m_taddr >> SW)) m_mem[i] = 16'hFFFF;
             m_st = 0;
           end
        default: if (reset_cmd_i) m_st = 0;
      endcase
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check("R10", "rvalid", 16'(rvalid_o), 16'(exp_v));
      if (exp_v) check(cur_req, "rdata", rdata_o, exp_d);
    end
  end

  task automatic rd(int a);
    @(negedge clk_i); rd_i = 1'b1; addr_i = AW'(a);
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic pulse_prog(int a, logic [15:0] d);
    @(negedge clk_i); start_prog_i = 1'b1; op_addr_i = AW'(a); op_data_i = d;
    @(negedge clk_i); start_prog_i = 1'b0;
  endtask

  task automatic pulse_erase(int a);
    @(negedge clk_i); start_erase_i = 1'b1; op_addr_i = AW'(a);
    @(negedge clk_i); start_erase_i = 1'b0;
  endtask

  task automatic pulse_done(bit tmo, bit dn);
    @(negedge clk_i); done_i = dn; timeout_i = tmo;
    @(negedge clk_i); done_i = 1'b0; timeout_i = 1'b0;
  endtask

  task automatic pulse_rcmd();
    @(negedge clk_i); reset_cmd_i = 1'b1;
    @(negedge clk_i); reset_cmd_i = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    check("R1", "rvalid at reset", 16'(rvalid_o), 16'h0);
    check("R1", "rdata at reset", rdata_o, 16'h0);
    rst_ni = 1'b1;
    rd(3); rd(17);

    cur_req = "R2";
    pulse_prog(3, 16'h1234);
    rd(3); rd(20); rd(7); rd(3);
    cur_req = "R3";
    pulse_done(0, 1);
    rd(3); rd(2); rd(4);

    cur_req = "R4";
    pulse_prog(3, 16'h1235);
    rd(3); rd(9);
    cur_req = "R9";
    pulse_erase(8);
    pulse_prog(5, 16'h0000);
    rd(8); rd(5);
    cur_req = "R6";
    pulse_done(0, 1);
    rd(3);
    pulse_rcmd();
    rd(3); rd(5);

    cur_req = "R11";
    pulse_prog(4, 16'h00F0);
    rd(4);
    pulse_done(1, 1);
    cur_req = "R5";
    rd(4); rd(4); rd(4);
    pulse_rcmd();
    rd(4);
    cur_req = "R9";
    pulse_done(0, 1);
    pulse_done(1, 0);
    pulse_rcmd();
    rd(4); rd(3);

    cur_req = "R3";
    pulse_prog(10, 16'hA5A5);
    pulse_done(0, 1);
    pulse_prog(24, 16'h0F0F);
    pulse_done(0, 1);
    rd(10); rd(24);

    cur_req = "R7";
    pulse_erase(9);
    rd(8); rd(9); rd(10); rd(11); rd(3); rd(24); rd(14); rd(16);
    cur_req = "R9";
    pulse_prog(10, 16'h0000);
    rd(10);
    cur_req = "R8";
    pulse_done(0, 1);
    for (int a = 8; a < 16; a++) rd(a);
    rd(3); rd(24); rd(7);

    cur_req = "R5";
    pulse_prog(25, 16'h1111);
    pulse_done(0, 1);
    pulse_erase(26);
    rd(24); rd(25); rd(27);
    pulse_done(1, 0);
    rd(26); rd(28); rd(25);
    cur_req = "R6";
    pulse_rcmd();
    rd(25); rd(24);

    repeat (3) @(negedge clk_i);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end
endmodule